// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block is the byte-wide data store of a small 8-bit controller core. It owns the bank pointer and the RAM array. It turns the operand of each data access into a 12-bit physical location in one of three ways. A banked access prefixes the 8-bit operand with the 4-bit bank pointer. A window access reaches low scratch RAM or the top special-register page in a single cycle, whatever the pointer holds. A full access carries the whole 12-bit location and never looks at the pointer.

The 4096-byte space holds sixteen 256-byte pages. Only the lowest pages exist as storage (three by default). Page 0xF is handed to an external special-register port, except for one fixed location that holds the bank pointer itself. Reads are combinational from the address inputs. Writes, bank loads and reset act on the rising clock edge.

Top module: `banked_dmem`

## Requirements
- R1: With `acc_mode` = 2'b00 (banked), the physical location is {bank pointer[3:0], `offset`[7:0]}.
- R2: With `acc_mode` = 2'b01 (window), an `offset` below 0x60 reaches location 0x000+`offset`, and an offset of 0x60 or above reaches 0xF00+`offset`. The bank pointer has no influence.
- R3: With `acc_mode` = 2'b10 or 2'b11 (full), the physical location is `full_addr` and the bank pointer is ignored.
- R4: Locations 0x000–0x2FF are storage. A write with `wr_en` high lands at the next rising edge, and a later read returns the stored byte.
- R5: Locations 0x300–0xEFF read as 0x00. Writes to them change no storage byte and give no indication.
- R6: The bank pointer sits at location 0xFE0. It reads as {4'b0000, pointer}, and a store there keeps only data bits 3:0.
- R7: `bank_ld` high loads `bank_lit`[3:0] into the bank pointer at the rising edge. Bits 7:4 of the literal are dropped.
- R8: Locations 0xF00–0xFFF other than 0xFE0 go to the special-register port. `sfr_addr` is the low address byte, `sfr_we` follows `wr_en`, and `rd_data` returns `sfr_rdata`. Accesses outside this page leave `sfr_we` low.
- R9: A synchronous active-high `rst` clears the bank pointer to 0.
- R10: A store in the same cycle as a bank load uses the pointer value from before the edge. If that store targets 0xFE0, the load literal wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_mode | input | 2 | 00 banked, 01 window, 1x full |
| offset | input | 8 | Low-order operand for banked and window accesses |
| full_addr | input | 12 | Complete location for full accesses |
| wr_en | input | 1 | Store strobe |
| wr_data | input | 8 | Store data |
| rd_data | output | 8 | Combinational read data |
| bank_ld | input | 1 | Load literal into bank pointer |
| bank_lit | input | 8 | Literal for bank load |
| sfr_addr | output | 8 | Special-register port location |
| sfr_we | output | 1 | Special-register port write strobe |
| sfr_wdata | output | 8 | Special-register port write data |
| sfr_rdata | input | 8 | Special-register port read data |

## Verification
A bank load and a data store can fall in the same cycle. The store must resolve its location with the old pointer while the load changes the pointer. The bench provokes this twice. First it runs a banked store together with a load to a different page, then reads both candidate locations back through full accesses. Second it runs a store to the pointer location together with a load, then reads 0xFE0 to confirm that the literal won.

// File: rtl/dm_pkg.sv
package dm_pkg;
    localparam int DM_DATA_W = 8;
    localparam int DM_OFS_W  = 8;
    localparam int DM_BANK_W = 4;
    localparam int DM_ADDR_W = DM_BANK_W + DM_OFS_W;

    typedef enum logic [1:0] {
        AM_BANKED = 2'b00,
        AM_WINDOW = 2'b01,
        AM_FULL   = 2'b10,
        AM_FULL2  = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        RG_RAM,
        RG_VOID,
        RG_SFR,
        RG_BANKREG
    } region_e;

    typedef struct packed {
        logic [DM_ADDR_W-1:0] addr;
        region_e              region;
    } dm_target_t;

    function automatic region_e dm_classify(
        input logic [DM_ADDR_W-1:0] a,
        input int unsigned          impl_banks,
        input logic [DM_BANK_W-1:0] sfr_bank,
        input logic [DM_OFS_W-1:0]  bankreg_ofs
    );
        if (a[DM_ADDR_W-1:DM_OFS_W] == sfr_bank) begin
            if (a[DM_OFS_W-1:0] == bankreg_ofs) return RG_BANKREG;
            return RG_SFR;
        end
        if (32'(a[DM_ADDR_W-1:DM_OFS_W]) < impl_banks) return RG_RAM;
        return RG_VOID;
    endfunction
endpackage

// File: rtl/dm_addr_gen.sv
module dm_addr_gen
    import dm_pkg::*;
#(
    parameter int unsigned          IMPL_BANKS  = 3,
    parameter logic [DM_OFS_W-1:0]  WIN_SPLIT   = 8'h60,
    parameter logic [DM_BANK_W-1:0] SFR_BANK    = 4'hF,
    parameter logic [DM_OFS_W-1:0]  BANKREG_OFS = 8'hE0
) (
    input  acc_mode_e              mode,
    input  logic [DM_OFS_W-1:0]    offset,
    input  logic [DM_ADDR_W-1:0]   full_addr,
    input  logic [DM_BANK_W-1:0]   bank,
    output dm_target_t             tgt
);
    localparam logic [DM_BANK_W-1:0] LOW_BANK = '0;

    logic [DM_ADDR_W-1:0] phys;

    always_comb begin
        unique case (mode)
            AM_BANKED: phys = {bank, offset};
            AM_WINDOW: phys = (offset < WIN_SPLIT) ? {LOW_BANK, offset}
                                                   : {SFR_BANK, offset};
            default:   phys = full_addr;
        endcase
        tgt.addr   = phys;
        tgt.region = dm_classify(phys, IMPL_BANKS, SFR_BANK, BANKREG_OFS);
    end

    // R2: a window access only ever reaches the low page or the register page
    always_comb begin
        if (mode == AM_WINDOW) begin
            p_window_pages_r2: assert (tgt.addr[DM_ADDR_W-1:DM_OFS_W] == LOW_BANK ||
                                       tgt.addr[DM_ADDR_W-1:DM_OFS_W] == SFR_BANK);
        end
    end
endmodule

// File: rtl/dm_bank_reg.sv
module dm_bank_reg
    import dm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld,
    input  logic [DM_DATA_W-1:0]  lit,
    input  logic                  st,
    input  logic [DM_DATA_W-1:0]  st_data,
    output logic [DM_BANK_W-1:0]  bank_q
);
    logic unused_hi;
    assign unused_hi = ^{lit[DM_DATA_W-1:DM_BANK_W], st_data[DM_DATA_W-1:DM_BANK_W]};

    always_ff @(posedge clk) begin
        if (rst)     bank_q <= '0;
        else if (ld) bank_q <= lit[DM_BANK_W-1:0];
        else if (st) bank_q <= st_data[DM_BANK_W-1:0];
    end

    // R7: a load takes the literal's low bits
    p_load_lit_r7: assert property (@(posedge clk) disable iff (rst)
        ld |=> bank_q == $past(lit[DM_BANK_W-1:0]));
    // R10: load beats a simultaneous store to the pointer
    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (ld && st) |=> bank_q != $past(st_data[DM_BANK_W-1:0]) ||
                       $past(st_data[DM_BANK_W-1:0]) == $past(lit[DM_BANK_W-1:0]));
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!ld && !st) |=> $stable(bank_q));
endmodule

// File: rtl/dm_ram.sv
module dm_ram
    import dm_pkg::*;
#(
    parameter int unsigned DEPTH = 768,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [DM_DATA_W-1:0]  wdata,
    output logic [DM_DATA_W-1:0]  rdata
);
    logic [DM_DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = (32'(idx) < DEPTH) ? mem[idx] : '0;

    // R5: storage is never written outside the implemented span
    p_we_in_span_r5: assert property (@(posedge clk) disable iff (rst)
        we |-> 32'(idx) < DEPTH);
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
    import dm_pkg::*;
#(
    parameter int unsigned          IMPL_BANKS  = 3,
    parameter logic [DM_OFS_W-1:0]  WIN_SPLIT   = 8'h60,
    parameter logic [DM_BANK_W-1:0] SFR_BANK    = 4'hF,
    parameter logic [DM_OFS_W-1:0]  BANKREG_OFS = 8'hE0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            acc_mode,
    input  logic [DM_OFS_W-1:0]   offset,
    input  logic [DM_ADDR_W-1:0]  full_addr,
    input  logic                  wr_en,
    input  logic [DM_DATA_W-1:0]  wr_data,
    output logic [DM_DATA_W-1:0]  rd_data,
    input  logic                  bank_ld,
    input  logic [DM_DATA_W-1:0]  bank_lit,
    output logic [DM_OFS_W-1:0]   sfr_addr,
    output logic                  sfr_we,
    output logic [DM_DATA_W-1:0]  sfr_wdata,
    input  logic [DM_DATA_W-1:0]  sfr_rdata
);
    localparam int unsigned RAM_DEPTH = IMPL_BANKS * (1 << DM_OFS_W);
    localparam int unsigned IDX_W     = $clog2(RAM_DEPTH);

    dm_target_t             tgt;
    logic [DM_BANK_W-1:0]   bank_q;
    logic [DM_DATA_W-1:0]   ram_rdata;
    logic                   ram_we;
    logic                   bank_st;

    dm_addr_gen #(
        .IMPL_BANKS (IMPL_BANKS),
        .WIN_SPLIT  (WIN_SPLIT),
        .SFR_BANK   (SFR_BANK),
        .BANKREG_OFS(BANKREG_OFS)
    ) u_agen (
        .mode     (acc_mode_e'(acc_mode)),
        .offset   (offset),
        .full_addr(full_addr),
        .bank     (bank_q),
        .tgt      (tgt)
    );

    assign ram_we  = wr_en && (tgt.region == RG_RAM);
    assign bank_st = wr_en && (tgt.region == RG_BANKREG);

    dm_bank_reg u_bank (
        .clk    (clk),
        .rst    (rst),
        .ld     (bank_ld),
        .lit    (bank_lit),
        .st     (bank_st),
        .st_data(wr_data),
        .bank_q (bank_q)
    );

    dm_ram #(
        .DEPTH(RAM_DEPTH),
        .IDX_W(IDX_W)
    ) u_ram (
        .clk  (clk),
        .rst  (rst),
        .we   (ram_we),
        .idx  (tgt.addr[IDX_W-1:0]),
        .wdata(wr_data),
        .rdata(ram_rdata)
    );

    assign sfr_addr  = tgt.addr[DM_OFS_W-1:0];
    assign sfr_we    = wr_en && (tgt.region == RG_SFR);
    assign sfr_wdata = wr_data;

    always_comb begin
        unique case (tgt.region)
            RG_RAM:     rd_data = ram_rdata;
            RG_SFR:     rd_data = sfr_rdata;
            RG_BANKREG: rd_data = {{(DM_DATA_W-DM_BANK_W){1'b0}}, bank_q};
            default:    rd_data = '0;
        endcase
    end

    // R5: missing pages read as zero
    p_void_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt.region == RG_VOID) |-> rd_data == '0);
    // R6: upper pointer bits never read as one
    p_ptr_hi_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (tgt.region == RG_BANKREG) |-> rd_data[DM_DATA_W-1:DM_BANK_W] == '0);
    // R8: the register port strobe only fires for the register page
    p_sfr_route_r8: assert property (@(posedge clk) disable iff (rst)
        sfr_we |-> wr_en && tgt.addr[DM_ADDR_W-1:DM_OFS_W] == SFR_BANK &&
                   tgt.addr[DM_OFS_W-1:0] != BANKREG_OFS);
endmodule

// File: tb/banked_dmem_tb.sv
module banked_dmem_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_mode = 2'b10;
    logic [7:0]  offset = '0;
    logic [11:0] full_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        bank_ld = 1'b0;
    logic [7:0]  bank_lit = '0;
    logic [7:0]  sfr_addr;
    logic        sfr_we;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;

    assign sfr_rdata = sfr_addr ^ 8'hA5;

    always #10 clk = ~clk;

    banked_dmem u_dut (
        .clk(clk), .rst(rst), .acc_mode(acc_mode), .offset(offset),
        .full_addr(full_addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bank_ld(bank_ld), .bank_lit(bank_lit),
        .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t   sbq[$];
    event       sb_ev;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] shadow [768];
    logic [3:0] mbank = '0;

    task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // monitor: pops expectations and compares with the live read port
    initial forever begin
        @(sb_ev);
        while (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            chk(it.tag, {4'h0, rd_data}, {4'h0, it.exp});
        end
    end

    function automatic logic [11:0] m_addr(input logic [1:0] m, input logic [7:0] o,
                                           input logic [11:0] f);
        if (m == 2'b00) return {mbank, o};
        if (m == 2'b01) return (o < 8'h60) ? {4'h0, o} : {4'hF, o};
        return f;
    endfunction

    function automatic logic [7:0] m_read(input logic [11:0] a);
        if (a[11:8] == 4'hF) return (a == 12'hFE0) ? {4'h0, mbank} : (a[7:0] ^ 8'hA5);
        if (a < 12'h300) return shadow[a];
        return 8'h00;
    endfunction

    // driver: applies one access, pushes the expected read, then lets the edge act
    task automatic op(input logic [1:0] m, input logic [7:0] o, input logic [11:0] f,
                      input logic we, input logic [7:0] wd, input logic ld,
                      input logic [7:0] lit, input string tag);
        logic [11:0] a;
        sb_item_t it;
        @(negedge clk);
        acc_mode = m; offset = o; full_addr = f; wr_en = we; wr_data = wd;
        bank_ld = ld; bank_lit = lit;
        #1;
        a = m_addr(m, o, f);
        it.exp = m_read(a);
        it.tag = tag;
        sbq.push_back(it);
        ->sb_ev;
        if (a[11:8] == 4'hF && a != 12'hFE0)
            chk({tag, " sfr_we"}, {11'h0, sfr_we}, {11'h0, we});
        else
            chk({tag, " sfr_we idle"}, {11'h0, sfr_we}, 12'h0);
        if (a[11:8] == 4'hF) chk({tag, " sfr_addr"}, {4'h0, sfr_addr}, {4'h0, a[7:0]});
        @(posedge clk);
        if (we && a < 12'h300) shadow[a] = wd;
        if (ld) mbank = lit[3:0];
        else if (we && a == 12'hFE0) mbank = wd[3:0];
        #1;
        wr_en = 1'b0; bank_ld = 1'b0;
    endtask

    task automatic rdf(input logic [11:0] f, input string tag);
        op(2'b10, 8'h00, f, 1'b0, 8'h00, 1'b0, 8'h00, tag);
    endtask
    task automatic wrf(input logic [11:0] f, input logic [7:0] d, input string tag);
        op(2'b10, 8'h00, f, 1'b1, d, 1'b0, 8'h00, tag);
    endtask
    task automatic ldb(input logic [7:0] lit, input string tag);
        op(2'b10, 8'h00, 12'hFE0, 1'b0, 8'h00, 1'b1, lit, tag);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state of the pointer
        rdf(12'hFE0, "R9 reset pointer");
        // R4 storage in all three pages
        wrf(12'h000, 8'h11, "R4 wr");
        wrf(12'h1FF, 8'h22, "R4 wr");
        wrf(12'h2FF, 8'h33, "R4 wr");
        wrf(12'h155, 8'h44, "R4 wr");
        wrf(12'h005, 8'h55, "R4 wr");
        wrf(12'h220, 8'hC3, "R4 wr");
        rdf(12'h000, "R4 rd p0");
        rdf(12'h1FF, "R4 rd p1");
        rdf(12'h2FF, "R4 rd p2");
        // R7 load with high literal bits set
        ldb(8'hF1, "R7 load");
        rdf(12'hFE0, "R7 pointer value");
        // R1 banked forming
        op(2'b00, 8'h55, 12'h000, 1'b0, 8'h00, 1'b0, 8'h00, "R1 banked rd");
        op(2'b00, 8'h10, 12'h000, 1'b1, 8'h5A, 1'b0, 8'h00, "R1 banked wr");
        rdf(12'h110, "R1 banked wr landed");
        // R2 window independent of pointer
        ldb(8'h02, "R2 set bank");
        op(2'b01, 8'h05, 12'h000, 1'b0, 8'h00, 1'b0, 8'h00, "R2 window low");
        op(2'b01, 8'h60, 12'h000, 1'b0, 8'h00, 1'b0, 8'h00, "R2 window split");
        op(2'b01, 8'hE0, 12'h000, 1'b0, 8'h00, 1'b0, 8'h00, "R2 window ptr");
        op(2'b01, 8'h07, 12'h000, 1'b1, 8'h77, 1'b0, 8'h00, "R2 window wr");
        rdf(12'h007, "R2 window wr landed");
        rdf(12'h207, "R2 page2 untouched");
        // R3 full ignores pointer; mode 11 too
        ldb(8'h01, "R3 set bank");
        rdf(12'h2FF, "R3 full rd");
        op(2'b11, 8'h00, 12'h155, 1'b0, 8'h00, 1'b0, 8'h00, "R3 full alt rd");
        // R5 missing pages
        wrf(12'h300, 8'h99, "R5 void wr");
        rdf(12'h300, "R5 void rd");
        rdf(12'h000, "R5 no alias");
        ldb(8'h07, "R5 set bank 7");
        op(2'b00, 8'h00, 12'h000, 1'b1, 8'hEE, 1'b0, 8'h00, "R5 banked void wr");
        op(2'b00, 8'h00, 12'h000, 1'b0, 8'h00, 1'b0, 8'h00, "R5 banked void rd");
        rdf(12'hE00, "R5 top void");
        rdf(12'h100, "R5 alias p1");
        // R6 pointer store keeps low bits
        wrf(12'hFE0, 8'hF6, "R6 ptr store");
        rdf(12'hFE0, "R6 ptr readback");
        op(2'b00, 8'h10, 12'h000, 1'b0, 8'h00, 1'b0, 8'h00, "R6 bank 6 void");
        // R8 register port
        wrf(12'hF42, 8'h3C, "R8 sfr wr");
        rdf(12'hF42, "R8 sfr rd");
        chk("R8 sfr wdata", {4'h0, sfr_wdata}, 12'h000);
        // R10 load and store in one cycle
        ldb(8'h01, "R10 set bank");
        op(2'b00, 8'h20, 12'h000, 1'b1, 8'h61, 1'b1, 8'h02, "R10 store+load");
        rdf(12'h120, "R10 old bank used");
        rdf(12'h220, "R10 new bank untouched");
        rdf(12'hFE0, "R10 bank loaded");
        op(2'b10, 8'h00, 12'hFE0, 1'b1, 8'h0B, 1'b1, 8'h01, "R10 ptr store+load");
        rdf(12'hFE0, "R10 literal wins");
        // R9 reset mid-run
        ldb(8'h05, "R9 set bank");
        @(negedge clk); rst = 1'b1;
        @(posedge clk); mbank = '0;
        @(negedge clk); rst = 1'b0;
        rdf(12'hFE0, "R9 reset clears");
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule